// File: doc/BRIEF.md
# Reservation-Table Initiation Gate

This block decides, cycle by cycle, whether a new task may be launched into a multi-function pipeline whose stages are visited in a non-linear order. The stage usage of one task is fixed at elaboration by a reservation table parameter. Bit `s*NUM_COLS + c` of `RES_TABLE` is 1 when stage `s` is busy `c` cycles after the task is accepted. The number of columns is the evaluation time of one task.

At elaboration the block turns the table into a collision vector: latency `L` is forbidden when some stage row has marks in two columns exactly `L` apart. At run time a shift register holds the latencies that are still forbidden with respect to every task in flight. A request is accepted only when the slot for the current cycle is clear. After each acceptance the collision vector is merged into the register. The block also reports which stages are in use, whether the pipeline holds any task, and whether a request at the next edge would be refused.

Top module: `cvpic_initiation_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. At the first falling edge after `rst` has been high for a rising edge, `init_grant`, `init_blocked`, `pipe_busy` and `stage_act` are all 0. Requests made while `rst` is high are never accepted, and tasks in flight are discarded.
- R2: With no task in flight, a request sampled high at a rising edge is accepted. `init_grant` is high for the single cycle that follows that edge.
- R3: A request at latency `L` after an earlier acceptance is refused exactly when some stage row of the table has marks in two columns `L` apart. The default table (stage 0 at columns 0 and 5, stage 1 at columns 1 and 3, stage 2 at columns 2 and 4) forbids latencies 2 and 5 only.
- R4: A refused request leaves no trace. Later decisions are the same as if it had not been made.
- R5: Latencies of `NUM_COLS` or more are never forbidden by the task they follow.
- R6: A request is accepted only when its latency is permissible with respect to every earlier task still within its evaluation time. The restrictions of several tasks accumulate.
- R7: `init_blocked` is high in a cycle exactly when a request sampled at the next rising edge would be refused.
- R8: `pipe_busy` is high in each of the `NUM_COLS` cycles that follow an acceptance, and low when no task is within that window.
- R9: `stage_act[s]` is high in the cycle `c` cycles after an acceptance (c = 0 is the cycle right after the accepting edge) when the table marks stage `s` at column `c`. No stage is ever claimed by two tasks in the same cycle.
- R10: A request held high is accepted at every edge where it is permissible. With the default table this gives acceptances at relative edges 0, 1, 4, 7, 8, 11, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| init_req | input | 1 | Request to launch a task at this edge |
| init_grant | output | 1 | High for the cycle after an accepting edge |
| init_blocked | output | 1 | A request at the next edge would be refused |
| pipe_busy | output | 1 | At least one task is still within its evaluation time |
| stage_act | output | NUM_STAGES | Per-stage use by the tasks in flight in this cycle |

## Verification
The decision for a request is taken at the rising edge where it is sampled. `init_grant` reflects that decision in the cycle after the edge, through one register. `stage_act`, `pipe_busy` and `init_blocked` describe the state after that same edge, and `init_blocked` looks ahead to the following edge. The bench drives each request just after a rising edge and records the expected outcome of that edge in a queue. It pops and compares at the next falling edge, so every result is read one edge after its stimulus.

Expected values come from a per-stage calendar of booked cycles, filled directly from the table. This is independent of the collision-vector arithmetic in the design. Directed probes cover each latency from 1 to 7, a refused request followed by a request that would be illegal only if the refusal had counted, accumulation over two tasks, a held request, and a reset taken while tasks are in flight. A long random pattern follows.

// File: rtl/cvpic_pkg.sv
package cvpic_pkg;

  // widest reservation table the helper below can inspect
  localparam int CVPIC_MAX_COLS = 64;

  // default table: 3 stages, 6 columns of evaluation time
  // stage0 cols 0,5 | stage1 cols 1,3 | stage2 cols 2,4
  localparam int              CVPIC_DEF_STAGES = 3;
  localparam int              CVPIC_DEF_COLS   = 6;
  localparam logic [17:0]     CVPIC_DEF_TABLE  = 18'h142A1;

  // true when one stage row has two marks exactly lat columns apart
  function automatic logic lat_collides(input logic [CVPIC_MAX_COLS-1:0] row,
                                        input int lat);
    return |(row & (row >> lat));
  endfunction

endpackage

// File: rtl/cvpic_cvec.sv
module cvpic_cvec #(
  parameter int NUM_STAGES = 3,
  parameter int NUM_COLS   = 6,
  parameter logic [NUM_STAGES*NUM_COLS-1:0] RES_TABLE = '0
) (
  output logic [NUM_COLS-2:0] cvec
);
  import cvpic_pkg::*;

  localparam int LAT_W = NUM_COLS - 1;

  logic [LAT_W-1:0][NUM_STAGES-1:0] hits;

  // bit L-1 of cvec marks latency L as forbidden
  for (genvar lat = 1; lat <= LAT_W; lat++) begin : g_lat
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      localparam logic [NUM_COLS-1:0] ROW = RES_TABLE[s*NUM_COLS +: NUM_COLS];
      assign hits[lat-1][s] = lat_collides(CVPIC_MAX_COLS'(ROW), lat);
    end
    assign cvec[lat-1] = |hits[lat-1];
  end

endmodule

// File: rtl/cvpic_gate.sv
module cvpic_gate #(
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [LAT_W-1:0] cvec,
  output logic             accept,
  output logic             grant_q,
  output logic             blocked_q
);

  // blk[k] set: acceptance k edges from the next one would collide
  logic [LAT_W-1:0] blk;
  logic [LAT_W-1:0] blk_nx;

  always_comb begin
    accept = req & ~blk[0];
    blk_nx = (blk >> 1) | (accept ? cvec : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk     <= '0;
      grant_q <= 1'b0;
    end else begin
      blk     <= blk_nx;
      grant_q <= accept;
    end
  end

  assign blocked_q = blk[0];

  assert_idle_grant_R2: assert property (@(posedge clk) disable iff (rst)
    (req && blk == '0) |=> grant_q);

  assert_refusal_no_trace_R4: assert property (@(posedge clk) disable iff (rst)
    (req && blk[0]) |=> (!grant_q && blk == ($past(blk) >> 1)));

  assert_merge_after_grant_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> ((blk & cvec) == cvec));

endmodule

// File: rtl/cvpic_occupancy.sv
module cvpic_occupancy #(
  parameter int NUM_STAGES = 3,
  parameter int NUM_COLS   = 6,
  parameter logic [NUM_STAGES*NUM_COLS-1:0] RES_TABLE = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  accept,
  output logic [NUM_STAGES-1:0] stage_act_q,
  output logic                  busy_q
);

  // hist[c]: a task accepted c edges before the latest one
  logic [NUM_COLS-1:0]   hist;
  logic [NUM_COLS-1:0]   hist_nx;
  logic [NUM_STAGES-1:0] act_nx;

  assign hist_nx = {hist[NUM_COLS-2:0], accept};

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam logic [NUM_COLS-1:0] ROW = RES_TABLE[s*NUM_COLS +: NUM_COLS];
    assign act_nx[s] = |(hist_nx & ROW);

    assert_one_owner_R9: assert property (@(posedge clk) disable iff (rst)
      $countones(hist & ROW) <= 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist        <= '0;
      stage_act_q <= '0;
      busy_q      <= 1'b0;
    end else begin
      hist        <= hist_nx;
      stage_act_q <= act_nx;
      busy_q      <= |hist_nx;
    end
  end

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_q);

endmodule

// File: rtl/cvpic_initiation_ctrl.sv
module cvpic_initiation_ctrl #(
  parameter int NUM_STAGES = cvpic_pkg::CVPIC_DEF_STAGES,
  parameter int NUM_COLS   = cvpic_pkg::CVPIC_DEF_COLS,
  parameter logic [NUM_STAGES*NUM_COLS-1:0] RES_TABLE = cvpic_pkg::CVPIC_DEF_TABLE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  init_req,
  output logic                  init_grant,
  output logic                  init_blocked,
  output logic                  pipe_busy,
  output logic [NUM_STAGES-1:0] stage_act
);

  localparam int LAT_W = NUM_COLS - 1;

  logic [LAT_W-1:0] cvec;
  logic             accept;

  cvpic_cvec #(
    .NUM_STAGES (NUM_STAGES),
    .NUM_COLS   (NUM_COLS),
    .RES_TABLE  (RES_TABLE)
  ) u_cvec (
    .cvec (cvec)
  );

  cvpic_gate #(
    .LAT_W (LAT_W)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .req       (init_req),
    .cvec      (cvec),
    .accept    (accept),
    .grant_q   (init_grant),
    .blocked_q (init_blocked)
  );

  cvpic_occupancy #(
    .NUM_STAGES (NUM_STAGES),
    .NUM_COLS   (NUM_COLS),
    .RES_TABLE  (RES_TABLE)
  ) u_occ (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept),
    .stage_act_q (stage_act),
    .busy_q      (pipe_busy)
  );

  assert_grant_implies_busy_R8: assert property (@(posedge clk) disable iff (rst)
    init_grant |-> pipe_busy);

  assert_greedy_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (init_req && !init_blocked) |=> init_grant);

  assert_blocked_refuses_R7: assert property (@(posedge clk) disable iff (rst)
    (init_req && init_blocked) |=> !init_grant);

endmodule

// File: tb/cvpic_initiation_ctrl_bench.sv
`timescale 1ns/1ps
module cvpic_initiation_ctrl_bench;

  localparam int NS = 3;
  localparam int NC = 6;
  localparam logic [NS*NC-1:0] TBL = 18'h142A1;
  localparam int DEPTH = 1200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          init_req = 1'b0;
  logic          init_grant, init_blocked, pipe_busy;
  logic [NS-1:0] stage_act;

  always #2.5 clk = ~clk;

  cvpic_initiation_ctrl #(.NUM_STAGES(NS), .NUM_COLS(NC), .RES_TABLE(TBL)) u_cvpic_initiation_ctrl (
    .clk(clk), .rst(rst), .init_req(init_req), .init_grant(init_grant),
    .init_blocked(init_blocked), .pipe_busy(pipe_busy), .stage_act(stage_act));

  int    total = 0;
  int    bad = 0;
  int    n = 0;
  bit    armed = 1'b0;
  string tag = "R2";

  bit cal [NS][DEPTH];
  bit gr  [DEPTH];
  bit bexp[DEPTH];

  typedef struct { int e; bit v; } exp_t;
  exp_t q[$];

  // bench model: a stage calendar booked straight from the table
  function automatic bit can_go(int k);
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        if (TBL[s*NC+c] && cal[s][k+c]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic void book(int k);
    gr[k] = 1'b1;
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++)
        if (TBL[s*NC+c]) cal[s][k+c] = 1'b1;
  endfunction

  function automatic bit busy_at(int j);
    for (int k = j - NC + 1; k <= j; k++)
      if (k >= 0 && gr[k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string rq, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", rq, act, expv, n);
    end
  endtask

  // driver: one request decision per rising edge
  task automatic step(bit r);
    exp_t x;
    init_req = r;
    x.e = n;
    x.v = r && !bexp[n];
    if (x.v) book(n);
    q.push_back(x);
    @(posedge clk);
    #1;
    n++;
    bexp[n] = !can_go(n);
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b0);
  endtask

  task automatic do_reset();
    armed = 1'b0;
    rst = 1'b1;
    init_req = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < DEPTH; i++) begin
      gr[i] = 1'b0;
      bexp[i] = 1'b0;
      for (int s = 0; s < NS; s++) cal[s][i] = 1'b0;
    end
    q.delete();
    n = 0;
    @(negedge clk);
    check(init_grant === 1'b0,   "R1", int'(init_grant), 0);
    check(init_blocked === 1'b0, "R1", int'(init_blocked), 0);
    check(pipe_busy === 1'b0,    "R1", int'(pipe_busy), 0);
    check(stage_act === '0,      "R1", int'(stage_act), 0);
    rst = 1'b0;
    init_req = 1'b0;
    armed = 1'b1;
  endtask

  // monitor: results of edge n-1 are read at the following falling edge
  always @(negedge clk) begin
    int   j;
    exp_t x;
    if (armed && n > 0) begin
      j = n - 1;
      if (q.size() > 0 && q[0].e == j) begin
        x = q.pop_front();
        check(init_grant === x.v, tag, int'(init_grant), int'(x.v));
      end
      for (int s = 0; s < NS; s++)
        check(stage_act[s] === cal[s][j], "R9", int'(stage_act[s]), int'(cal[s][j]));
      check(pipe_busy === busy_at(j), "R8", int'(pipe_busy), int'(busy_at(j)));
      check(init_blocked === bexp[n], "R7", int'(init_blocked), int'(bexp[n]));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    tag = "R2";                         // idle pipeline accepts at once
    step(1'b1); idle(8);

    for (int lat = 1; lat <= 7; lat++) begin
      tag = (lat >= NC) ? "R5" : "R3";  // 2 and 5 must be refused
      step(1'b1); idle(lat - 1); step(1'b1); idle(8);
    end

    tag = "R4";                         // refused at +2, then +4 must pass
    step(1'b1); step(1'b0); step(1'b1); step(1'b0); step(1'b1); idle(8);

    tag = "R6";                         // two tasks: +2,+3 refused, +4 taken
    step(1'b1); step(1'b1); step(1'b1); step(1'b1); step(1'b1); idle(8);

    tag = "R10";                        // held request, greedy admission
    repeat (30) step(1'b1);
    idle(8);

    tag = "R1";                         // reset while tasks are in flight
    step(1'b1); step(1'b0);
    do_reset();
    tag = "R2";
    step(1'b1); idle(8);

    tag = "R6";
    repeat (300) step(bit'($urandom_range(0, 1)));
    idle(8);

    @(negedge clk);
    #1;
    armed = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule